// File: doc/BRIEF.md
# Opcode-Selected Conditional Jump Gate

This block decides, during a jump instruction, whether the program counter takes the new address. Every jump opcode runs the same microcode. The microcode raises a conditional-jump enable. The block then picks one of eight conditions using the three least significant bits of the instruction register: one of four status flags, or the complement of one of them. The selected condition becomes the program counter's load enable. The decision never feeds back into the microcode address, so a jump that is not taken still runs all of its steps. The program counter simply keeps its value, and the instruction behaves as a long no-operation.

A separate unconditional write request merges with the conditional path. Either source can load the counter. The output is purely combinational, and the program counter samples it on its next rising clock edge. Flag storage, the counter itself and microcode sequencing sit outside this block.

Top module: `jump_gate`

## Requirements
- R1: Flag bits are packed as bit 0 = carry, bit 1 = zero, bit 2 = overflow, bit 3 = negative. With the enable high and the write request low, select codes 0 to 3 make `pc_load_o` equal to the flag bit at that index.
- R2: With the enable high and the write request low, select codes 4 to 7 make `pc_load_o` equal to the complement of the flag bit at index (code - 4).
- R3: The select code is bits [2:0] of `ir_i`. Bits above bit 2 have no effect on `pc_load_o`.
- R4: With both the enable and the write request low, `pc_load_o` is 0 for every flag value and every instruction register value.
- R5: With the write request high, `pc_load_o` is 1 for every flag value, enable value and instruction register value.
- R6: `pc_load_o` has no register in its path. It reflects any input change within the same clock cycle, before the next rising edge.
- R7: A not-taken condition with the enable high leaves `pc_load_o` at 0, so the jump steps complete without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_i | input | IR_W (8) | Instruction register contents; the low three bits choose the condition |
| flags_i | input | NUM_FLAGS (4) | Current status flags: carry, zero, overflow, negative |
| jump_en_i | input | 1 | Conditional jump enable from microcode |
| pc_write_i | input | 1 | Unconditional program counter write request |
| pc_load_o | output | 1 | Active-high program counter load enable |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and `pc_load_o`. The bench applies each input set on the falling clock edge. It samples one nanosecond later, well before the next rising edge, so no check depends on edge ordering. The settle check changes flags in the middle of a cycle and expects the new value before the next rising edge. An extra register would make that check fail. The exhaustive sweep checks every combination of flags, select code, enable and write request against a value that the bench computes from the requirements.

// File: rtl/jump_gate_pkg.sv
// Package: shared widths and the condition code encoding for the jump gate.
// Assumes four status flags, each with a true form and a complemented form.
package jump_gate_pkg;
    localparam int unsigned JG_NUM_FLAGS = 4;
    localparam int unsigned JG_IR_W      = 8;

    // Condition codes carried in the low opcode bits.
    typedef enum logic [2:0] {
        COND_C    = 3'd0,
        COND_Z    = 3'd1,
        COND_V    = 3'd2,
        COND_N    = 3'd3,
        COND_NOTC = 3'd4,
        COND_NOTZ = 3'd5,
        COND_NOTV = 3'd6,
        COND_NOTN = 3'd7
    } cond_e;
endpackage

// File: rtl/jump_gate_cands.sv
// Module: builds the candidate vector of true flags followed by complemented
// flags. Assumes candidates [NUM_FLAGS-1:0] are true forms, upper half inverted.
module jump_gate_cands #(
    parameter int unsigned NUM_FLAGS = 4,
    localparam int unsigned NCAND    = 2 * NUM_FLAGS
) (
    input  logic [NUM_FLAGS-1:0] flags_i,
    output logic [NCAND-1:0]     cand_o
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_pair
        // True and complemented form of one flag.
        assign cand_o[g]             = flags_i[g];
        assign cand_o[g + NUM_FLAGS] = ~flags_i[g];
    end
endmodule

// File: rtl/jump_gate_mux.sv
// Module: selects one candidate by index. Assumes the index is always in range
// (NCAND is a power of two, so every code maps to a candidate).
module jump_gate_mux #(
    parameter int unsigned NCAND = 8,
    localparam int unsigned SEL_W = $clog2(NCAND)
) (
    input  logic [NCAND-1:0] cand_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             pick_o
);
    // Index into the candidate vector.
    always_comb begin
        pick_o = cand_i[sel_i];
    end
endmodule

// File: rtl/jump_gate.sv
// Module: conditional jump gate. It chooses a flag or its complement with the
// low IR bits, gates that with the jump enable and merges the result with the
// unconditional write. Assumes the program counter registers pc_load_o on its
// own clock. This block holds no state, so it needs no clock or reset.
module jump_gate
    import jump_gate_pkg::*;
#(
    parameter int unsigned IR_W      = JG_IR_W,
    parameter int unsigned NUM_FLAGS = JG_NUM_FLAGS,
    localparam int unsigned NCAND    = 2 * NUM_FLAGS,
    localparam int unsigned SEL_W    = $clog2(NCAND)
) (
    input  logic [IR_W-1:0]      ir_i,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 jump_en_i,
    input  logic                 pc_write_i,
    output logic                 pc_load_o
);
    logic [NCAND-1:0] cand;
    logic [SEL_W-1:0] sel;
    logic             pick;
    logic             taken;
    logic             load_n;

    assign sel = ir_i[SEL_W-1:0];

    jump_gate_cands #(.NUM_FLAGS(NUM_FLAGS)) u_cands (
        .flags_i (flags_i),
        .cand_o  (cand)
    );

    jump_gate_mux #(.NCAND(NCAND)) u_mux (
        .cand_i (cand),
        .sel_i  (sel),
        .pick_o (pick)
    );

    // Gate the chosen condition with the microcode enable.
    always_comb begin
        taken = jump_en_i & pick;
    end

    // Merge both load sources as a NOR followed by inversion.
    always_comb begin
        load_n    = ~(taken | pc_write_i);
        pc_load_o = ~load_n;
    end
endmodule

// File: rtl/jump_gate_chk.sv
// Checker: immediate assertions on the gate's ports. Assumes the ports settle
// combinationally, which is the block's contract.
module jump_gate_chk #(
    parameter int unsigned IR_W      = 8,
    parameter int unsigned NUM_FLAGS = 4
) (
    input logic [IR_W-1:0]      ir_i,
    input logic [NUM_FLAGS-1:0] flags_i,
    input logic                 jump_en_i,
    input logic                 pc_write_i,
    input logic                 pc_load_o
);
    logic [2:0] code;
    assign code = ir_i[2:0];

    // Port relations checked whenever an input changes.
    always_comb begin
        if (!jump_en_i && !pc_write_i)
            a_r4_idle_no_load: assert (pc_load_o == 1'b0);
        if (pc_write_i)
            a_r5_write_forces: assert (pc_load_o == 1'b1);
        if (jump_en_i && !pc_write_i && !code[2])
            a_r1_true_flag: assert (pc_load_o == flags_i[code[1:0]]);
        if (jump_en_i && !pc_write_i && code[2])
            a_r2_inv_flag: assert (pc_load_o == !flags_i[code[1:0]]);
    end
endmodule

bind jump_gate jump_gate_chk #(.IR_W(IR_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
    .ir_i       (ir_i),
    .flags_i    (flags_i),
    .jump_en_i  (jump_en_i),
    .pc_write_i (pc_write_i),
    .pc_load_o  (pc_load_o)
);

// File: tb/test_jump_gate.sv
// Directed bench for jump_gate: one task per scenario, each checking its own results.
module test_jump_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ir;
    logic [3:0] flags;
    logic       en;
    logic       wr;
    logic       load;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    jump_gate i_jump_gate (
        .ir_i       (ir),
        .flags_i    (flags),
        .jump_en_i  (en),
        .pc_write_i (wr),
        .pc_load_o  (load)
    );

    // Model built from the requirements.
    function automatic logic model(logic [7:0] i, logic [3:0] f, logic e, logic w);
        logic c;
        c = i[2] ? ~f[i[1:0]] : f[i[1:0]];
        return w | (e & c);
    endfunction

    task automatic chk(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b ir=%h flags=%b en=%b wr=%b",
                     req, got, exp, ir, flags, en, wr);
        end
    endtask

    task automatic apply(logic [7:0] i, logic [3:0] f, logic e, logic w);
        @(negedge clk);
        ir = i; flags = f; en = e; wr = w;
        #1;
    endtask

    task automatic t_reset_state();
        apply(8'h00, 4'h0, 1'b0, 1'b0);
        chk("R4 reset state", load, 1'b0);
    endtask

    task automatic t_true_flags();
        for (int s = 0; s < 4; s++) begin
            apply(8'(s), 4'(1 << s), 1'b1, 1'b0);
            chk("R1 flag set taken", load, 1'b1);
            apply(8'(s), ~4'(1 << s), 1'b1, 1'b0);
            chk("R1 flag clear not taken", load, 1'b0);
        end
    endtask

    task automatic t_inv_flags();
        for (int s = 4; s < 8; s++) begin
            apply(8'(s), ~4'(1 << (s - 4)), 1'b1, 1'b0);
            chk("R2 flag clear taken", load, 1'b1);
            apply(8'(s), 4'(1 << (s - 4)), 1'b1, 1'b0);
            chk("R7 not taken no load", load, 1'b0);
        end
    endtask

    task automatic t_ir_upper();
        for (int u = 0; u < 32; u++) begin
            apply({5'(u), 3'd1}, 4'b0010, 1'b1, 1'b0);
            chk("R3 upper bits ignored zero set", load, 1'b1);
            apply({5'(u), 3'd6}, 4'b0100, 1'b1, 1'b0);
            chk("R3 upper bits ignored V set", load, 1'b0);
        end
    endtask

    task automatic t_disabled();
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 256; i += 37) begin
                apply(8'(i), 4'(f), 1'b0, 1'b0);
                chk("R4 disabled", load, 1'b0);
            end
    endtask

    task automatic t_uncond();
        for (int f = 0; f < 16; f++) begin
            apply(8'(f * 13), 4'(f), f[0], 1'b1);
            chk("R5 write forces load", load, 1'b1);
        end
    endtask

    task automatic t_settle();
        apply(8'd3, 4'b0000, 1'b1, 1'b0);
        chk("R6 before change", load, 1'b0);
        flags = 4'b1000;
        #0.5;
        chk("R6 same-cycle update", load, 1'b1);
    endtask

    task automatic t_sweep();
        for (int f = 0; f < 16; f++)
            for (int s = 0; s < 8; s++)
                for (int m = 0; m < 4; m++) begin
                    apply(8'(s), 4'(f), m[0], m[1]);
                    chk("R7 sweep", load, model(8'(s), 4'(f), m[0], m[1]));
                end
    endtask

    initial begin
        ir = '0; flags = '0; en = 1'b0; wr = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_true_flags();
        t_inv_flags();
        t_ir_upper();
        t_disabled();
        t_uncond();
        t_settle();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule